// File: doc/BRIEF.md
# External Bus Sizing Strobe Controller

This block sits between a requester that issues byte, word and longword accesses and a 16-bit external data bus. It accepts one request at a time, checks its alignment, and runs one or two fixed-length bus cycles. During each cycle it places the address, steers write data onto the proper byte lanes, and drives a read strobe or one or both lane write strobes. Read data taken from the bus is packed into a 32-bit result and returned with a one-clock done pulse.

Byte order on the bus is big-endian. The byte at an even address travels on the upper lane (bits 15:8) and the byte at an odd address on the lower lane (bits 7:0). A longword is carried as two word cycles, the more significant word first at the request address and the less significant word second at the address plus two. Each bus cycle has a setup state followed by a strobe state. Strobes are active only in the strobe state, and the address does not change during the cycle.

Top module: `ext_bus_sizer`

## Requirements
- R1: The size code is 0 for byte, 1 for word, 2 for longword and 3 for invalid. A request with size 3, or a word or longword request whose address bit 0 is 1, produces a one-clock `err` pulse in the cycle after acceptance. It runs no bus cycle, never raises `busy` and gives no `done`.
- R2: Each bus cycle lasts two clocks, a setup clock and then a strobe clock. `bus_rd`, `bus_wr_hi` and `bus_wr_lo` are asserted only in the strobe clock. `bus_addr` holds the cycle's address through both clocks.
- R3: A byte write to an even address asserts only `bus_wr_hi`. A byte write to an odd address asserts only `bus_wr_lo`.
- R4: During a byte write, `bus_dout` carries the write byte `req_wdata[7:0]` on both lanes.
- R5: A read asserts `bus_rd` and neither write strobe. A byte read returns the addressed lane, the upper lane for even and the lower lane for odd, zero-extended in `rdata[7:0]`.
- R6: A word access uses one bus cycle. A word write asserts both write strobes with `req_wdata[15:8]` on the upper lane and `req_wdata[7:0]` on the lower lane. A word read returns `bus_din` zero-extended in `rdata[15:0]`.
- R7: A longword access uses two bus cycles, at the request address and then at the address plus 2. A write sends `req_wdata[31:16]` in the first cycle and `req_wdata[15:0]` in the second. A read returns the first cycle's data in `rdata[31:16]` and the second cycle's data in `rdata[15:0]`.
- R8: `busy` is high from the clock after acceptance until the last strobe clock ends. `done` is a one-clock pulse in the clock where `busy` falls, with `rdata` valid at that time.
- R9: `req_valid` is ignored while `busy` is high. The running access keeps its address, data and strobes, and the ignored request never runs.
- R10: `bus_oe` is high in both clocks of every write cycle and low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present; accepted when not busy |
| req_write | input | 1 | 1 for write, 0 for read |
| req_size | input | 2 | 0 byte, 1 word, 2 longword, 3 invalid |
| req_addr | input | AW | Byte address of the access |
| req_wdata | input | 32 | Write data, right-justified for byte and word |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-clock completion pulse |
| err | output | 1 | One-clock misalignment / invalid size pulse |
| rdata | output | 32 | Assembled read data, valid with done |
| bus_addr | output | AW | External bus address |
| bus_dout | output | 16 | Data driven to the bus |
| bus_oe | output | 1 | Output enable for bus_dout |
| bus_din | input | 16 | Data returned from the bus |
| bus_rd | output | 1 | Read strobe, both lanes |
| bus_wr_hi | output | 1 | Write strobe, upper lane |
| bus_wr_lo | output | 1 | Write strobe, lower lane |

## Verification
The hardest behaviour to reach from the ports is a new request arriving while an access is running, especially between the two halves of a longword. That new request has different size, direction and address. The bench keeps `req_valid` high with such a request for the whole access and removes it only in the clock where `done` appears. It then checks that the first access's address, data lanes and strobes did not change and that no extra cycle followed. A device model returns bytes computed from the address, so every lane and word-order mistake shows up as a wrong value in `rdata`.

// File: rtl/ebs_pkg.sv
package ebs_pkg;

  localparam int BUS_W  = 16;
  localparam int LANE_W = 8;
  localparam int REQ_W  = 32;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_BAD  = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_STROBE = 2'd2
  } bus_state_e;

  // Invalid code, or a multi-byte access at an odd address.
  function automatic logic f_misaligned(acc_size_e s, logic a0);
    return (s == SZ_BAD) || ((s != SZ_BYTE) && a0);
  endfunction

  // Lane enables {upper, lower} for an access.
  function automatic logic [1:0] f_wr_lanes(acc_size_e s, logic a0);
    if (s == SZ_BYTE) return a0 ? 2'b01 : 2'b10;
    return 2'b11;
  endfunction

  // Data placed on the 16-bit bus for the current cycle.
  function automatic logic [BUS_W-1:0] f_steer_wdata(acc_size_e s, logic second,
                                                     logic [REQ_W-1:0] wd);
    logic [BUS_W-1:0] v;
    case (s)
      SZ_BYTE: v = {wd[LANE_W-1:0], wd[LANE_W-1:0]};
      SZ_LONG: v = second ? wd[BUS_W-1:0] : wd[REQ_W-1:BUS_W];
      default: v = wd[BUS_W-1:0];
    endcase
    return v;
  endfunction

  // Read result from the captured first word and the current bus data.
  function automatic logic [REQ_W-1:0] f_merge(acc_size_e s, logic a0,
                                               logic [BUS_W-1:0] first,
                                               logic [BUS_W-1:0] din);
    logic [REQ_W-1:0] v;
    case (s)
      SZ_BYTE: v = {{(REQ_W-LANE_W){1'b0}}, a0 ? din[LANE_W-1:0] : din[BUS_W-1:LANE_W]};
      SZ_LONG: v = {first, din};
      default: v = {{(REQ_W-BUS_W){1'b0}}, din};
    endcase
    return v;
  endfunction

endpackage

// File: rtl/ebs_seq.sv
module ebs_seq
  import ebs_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  acc_size_e        req_size,
  input  logic [AW-1:0]    req_addr,
  input  logic [REQ_W-1:0] req_wdata,
  output bus_state_e       state_q,
  output logic             second_q,
  output acc_size_e        size_q,
  output logic             write_q,
  output logic [AW-1:0]    addr_q,
  output logic [REQ_W-1:0] wdata_q,
  output logic             busy,
  output logic             err_q,
  output logic             end_first,
  output logic             end_last
);

  localparam logic [AW-1:0] WORD_STEP = AW'(2);

  logic accept;
  logic bad_req;

  assign accept    = req_valid && (state_q == ST_IDLE);
  assign bad_req   = f_misaligned(req_size, req_addr[0]);
  assign busy      = (state_q != ST_IDLE);
  assign end_first = (state_q == ST_STROBE) && (size_q == SZ_LONG) && !second_q;
  assign end_last  = (state_q == ST_STROBE) && !end_first;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      second_q <= 1'b0;
      size_q   <= SZ_BYTE;
      write_q  <= 1'b0;
      addr_q   <= '0;
      wdata_q  <= '0;
      err_q    <= 1'b0;
    end else begin
      err_q <= accept && bad_req;
      case (state_q)
        ST_IDLE: begin
          if (accept && !bad_req) begin
            state_q  <= ST_SETUP;
            second_q <= 1'b0;
            size_q   <= req_size;
            write_q  <= req_write;
            addr_q   <= req_addr;
            wdata_q  <= req_wdata;
          end
        end
        ST_SETUP: state_q <= ST_STROBE;
        ST_STROBE: begin
          if (end_first) begin
            state_q  <= ST_SETUP;
            second_q <= 1'b1;
            addr_q   <= addr_q + WORD_STEP;
          end else begin
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  p_err_no_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> !busy);

  p_strobe_after_setup_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STROBE) |-> ($past(state_q) == ST_SETUP));

  p_addr_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STROBE) |-> $stable(addr_q));

  p_long_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(second_q)) |-> (addr_q == $past(addr_q) + WORD_STEP));

  p_ignore_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !end_last) |=> ($stable(write_q) && $stable(size_q) && $stable(wdata_q)));

endmodule

// File: rtl/ebs_lane_steer.sv
module ebs_lane_steer
  import ebs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  bus_state_e       state_q,
  input  acc_size_e        size_q,
  input  logic             write_q,
  input  logic             addr0,
  input  logic             second_q,
  input  logic [REQ_W-1:0] wdata_q,
  output logic [BUS_W-1:0] bus_dout,
  output logic             bus_oe,
  output logic             bus_rd,
  output logic             bus_wr_hi,
  output logic             bus_wr_lo
);

  logic       in_cycle;
  logic       strobe_ph;
  logic [1:0] lanes;
  logic       any_strobe;

  assign in_cycle   = (state_q != ST_IDLE);
  assign strobe_ph  = (state_q == ST_STROBE);
  assign lanes      = f_wr_lanes(size_q, addr0);

  assign bus_rd     = strobe_ph && !write_q;
  assign bus_wr_hi  = strobe_ph && write_q && lanes[1];
  assign bus_wr_lo  = strobe_ph && write_q && lanes[0];
  assign bus_oe     = in_cycle && write_q;
  assign bus_dout   = f_steer_wdata(size_q, second_q, wdata_q);
  assign any_strobe = bus_rd || bus_wr_hi || bus_wr_lo;

  p_rd_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |-> !(bus_wr_hi || bus_wr_lo));

  p_strobe_one_clock_r2: assert property (@(posedge clk) disable iff (!rst_n)
    any_strobe |=> !any_strobe);

  p_byte_one_lane_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (write_q && strobe_ph && size_q == SZ_BYTE) |-> ($countones({bus_wr_hi, bus_wr_lo}) == 1));

  p_wr_with_oe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_hi || bus_wr_lo) |-> bus_oe);

endmodule

// File: rtl/ebs_read_merge.sv
module ebs_read_merge
  import ebs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             end_first,
  input  logic             end_last,
  input  acc_size_e        size_q,
  input  logic             addr0,
  input  logic [BUS_W-1:0] bus_din,
  output logic [REQ_W-1:0] rdata,
  output logic             done
);

  logic [BUS_W-1:0] first_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= '0;
      rdata   <= '0;
      done    <= 1'b0;
    end else begin
      done <= end_last;
      if (end_first) first_q <= bus_din;
      if (end_last)  rdata   <= f_merge(size_q, addr0, first_q, bus_din);
    end
  end

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: rtl/ext_bus_sizer.sv
module ext_bus_sizer
  import ebs_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [1:0]    req_size,
  input  logic [AW-1:0] req_addr,
  input  logic [31:0]   req_wdata,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic [31:0]   rdata,
  output logic [AW-1:0] bus_addr,
  output logic [15:0]   bus_dout,
  output logic          bus_oe,
  input  logic [15:0]   bus_din,
  output logic          bus_rd,
  output logic          bus_wr_hi,
  output logic          bus_wr_lo
);

  bus_state_e       state_q;
  acc_size_e        size_q;
  logic             second_q;
  logic             write_q;
  logic [REQ_W-1:0] wdata_q;
  logic             end_first;
  logic             end_last;

  ebs_seq #(.AW(AW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_size  (acc_size_e'(req_size)),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .state_q   (state_q),
    .second_q  (second_q),
    .size_q    (size_q),
    .write_q   (write_q),
    .addr_q    (bus_addr),
    .wdata_q   (wdata_q),
    .busy      (busy),
    .err_q     (err),
    .end_first (end_first),
    .end_last  (end_last)
  );

  ebs_lane_steer u_steer (
    .clk       (clk),
    .rst_n     (rst_n),
    .state_q   (state_q),
    .size_q    (size_q),
    .write_q   (write_q),
    .addr0     (bus_addr[0]),
    .second_q  (second_q),
    .wdata_q   (wdata_q),
    .bus_dout  (bus_dout),
    .bus_oe    (bus_oe),
    .bus_rd    (bus_rd),
    .bus_wr_hi (bus_wr_hi),
    .bus_wr_lo (bus_wr_lo)
  );

  ebs_read_merge u_merge (
    .clk       (clk),
    .rst_n     (rst_n),
    .end_first (end_first),
    .end_last  (end_last),
    .size_q    (size_q),
    .addr0     (bus_addr[0]),
    .bus_din   (bus_din),
    .rdata     (rdata),
    .done      (done)
  );

  p_done_on_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_err_no_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !(bus_rd || bus_wr_hi || bus_wr_lo || bus_oe));

endmodule

// File: tb/test_ext_bus_sizer.sv
module test_ext_bus_sizer;

  localparam int CLK_P = 10;
  localparam int AW    = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [1:0]    req_size = 2'd0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic          busy, done, err;
  logic [31:0]   rdata;
  logic [AW-1:0] bus_addr;
  logic [15:0]   bus_dout;
  logic          bus_oe;
  logic [15:0]   bus_din;
  logic          bus_rd, bus_wr_hi, bus_wr_lo;

  int checks = 0;
  int failures = 0;

  always #(CLK_P/2) clk = ~clk;

  ext_bus_sizer #(.AW(AW)) i_ext_bus_sizer (
    .clk, .rst_n, .req_valid, .req_write, .req_size, .req_addr, .req_wdata,
    .busy, .done, .err, .rdata, .bus_addr, .bus_dout, .bus_oe, .bus_din,
    .bus_rd, .bus_wr_hi, .bus_wr_lo
  );

  function automatic logic [7:0] mem_byte(logic [AW-1:0] a);
    logic [AW-1:0] t;
    t = a * AW'(37) + AW'(11);
    return t[7:0];
  endfunction

  // Device model: returns both bytes of the addressed halfword.
  always_comb bus_din = {mem_byte({bus_addr[AW-1:1], 1'b0}), mem_byte({bus_addr[AW-1:1], 1'b1})};

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic run_acc(input logic [AW-1:0] a, input int sz, input bit wr, input bit hold);
    logic [31:0] wd;
    bit bad;
    int last;
    string stb_tag, dat_tag, adr_tag, ctl_tag;
    wd   = {a[7:0] ^ 8'hC3, a[7:0] + 8'h11, ~a[7:0], a[7:0] * 8'd3 + 8'd1};
    bad  = (sz == 3) || (sz != 0 && a[0]);
    last = (sz == 2) ? 4 : 2;
    stb_tag = bad ? "R1" : (!wr ? "R5" : (sz == 0 ? "R3" : (sz == 2 ? "R7" : "R6")));
    dat_tag = (sz == 0) ? "R4" : ((sz == 2) ? "R7" : "R6");
    adr_tag = (sz == 2) ? "R7" : "R2";
    ctl_tag = bad ? "R1" : (hold ? "R9" : "R8");
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_size = sz[1:0]; req_addr = a; req_wdata = wd;
    for (int k = 1; k <= 6; k++) begin
      bit inb, t2, e_hi, e_lo;
      logic [15:0] e_dout;
      logic [31:0] e_rd;
      @(negedge clk);
      if (bad) begin
        chk({busy, done, err} == {2'b00, k == 1}, "R1", {busy, done, err}, {2'b00, k == 1});
        chk({bus_rd, bus_wr_hi, bus_wr_lo, bus_oe} == 4'b0, "R1",
            {bus_rd, bus_wr_hi, bus_wr_lo, bus_oe}, 0);
      end else begin
        inb  = (k <= last);
        t2   = inb && (k % 2 == 0);
        e_hi = t2 && wr && (sz != 0 || !a[0]);
        e_lo = t2 && wr && (sz != 0 || a[0]);
        chk({busy, done, err} == {inb, k == last + 1, 1'b0}, ctl_tag,
            {busy, done, err}, {inb, k == last + 1, 1'b0});
        chk({bus_rd, bus_wr_hi, bus_wr_lo} == {t2 && !wr, e_hi, e_lo}, stb_tag,
            {bus_rd, bus_wr_hi, bus_wr_lo}, {t2 && !wr, e_hi, e_lo});
        chk(bus_oe == (inb && wr), "R10", bus_oe, inb && wr);
        if (inb) begin
          chk(bus_addr == a + ((k > 2) ? AW'(2) : AW'(0)), adr_tag, bus_addr,
              a + ((k > 2) ? AW'(2) : AW'(0)));
          if (wr) begin
            if (sz == 0) e_dout = {wd[7:0], wd[7:0]};
            else if (sz == 2) e_dout = (k > 2) ? wd[15:0] : wd[31:16];
            else e_dout = wd[15:0];
            chk(bus_dout == e_dout, dat_tag, bus_dout, e_dout);
          end
        end
        if (k == last + 1 && !wr) begin
          if (sz == 0) e_rd = {24'h0, mem_byte(a)};
          else if (sz == 1) e_rd = {16'h0, mem_byte(a), mem_byte(a + 1)};
          else e_rd = {mem_byte(a), mem_byte(a + 1), mem_byte(a + 2), mem_byte(a + 3)};
          chk(rdata == e_rd, dat_tag == "R4" ? "R5" : dat_tag, rdata, e_rd);
        end
      end
      if (hold) begin
        if (k == 1) begin
          req_write = !wr; req_size = 2'd0; req_addr = a + AW'(5); req_wdata = ~wd;
        end
        if (k == last + 1) req_valid = 1'b0;
      end else if (k == 1) begin
        req_valid = 1'b0;
      end
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    failures++;
    $display("FAIL watchdog R8 actual=%0d expected=0", 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({busy, done, err, bus_rd, bus_wr_hi, bus_wr_lo, bus_oe} == 7'b0, "R8",
        {busy, done, err, bus_rd, bus_wr_hi, bus_wr_lo, bus_oe}, 0);
    for (int sz = 0; sz < 4; sz++)
      for (int wr = 0; wr < 2; wr++)
        for (int a = 0; a < 12; a++)
          run_acc(AW'(a), sz, wr[0], 1'b0);
    run_acc(16'hFFFE, 2, 1'b0, 1'b0);
    run_acc(16'h7FF3, 0, 1'b1, 1'b0);
    for (int sz = 0; sz < 3; sz++)
      for (int wr = 0; wr < 2; wr++)
        run_acc(AW'(16'h0120 + sz * 4), sz, wr[0], 1'b1);
    run_acc(16'h0203, 0, 1'b1, 1'b1);
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule